// File: doc/BRIEF.md
# APB Slave Address Expander

This block sits between a narrow APB3 master and the address bus that fans out to the peripherals. A master that drives only 12 to 28 address bits still needs to reach a full 32-bit slave address. The block forms that address from three sources:

- the master's low address bits, which are copied directly;
- the master's top four address bits, which can be moved up to a higher nibble of the slave address or left out entirely;
- an upper-bit source for every remaining bit, taken at the same bit index.

The upper-bit source is set at build time. It can be zero, a 32-bit input port, or a register held inside the block. That register is mapped into one of the sixteen slave slots. Its layout follows the data bus width: one 32-bit word, two 16-bit halves, or four bytes. The block returns the register's read data, a slot-hit flag, ready and error. The system's read-data mux merges these with the other slaves.

The register clears on an asynchronous active-low reset, and the reset is released synchronously through a two-stage pipeline. For two clock cycles after reset is released, register writes have no effect.

Top module: `apb_addr_expander`

## Requirements
- R1: When MA_W < 32, slave_addr[MA_W-5:0] equals paddr[MA_W-5:0].
- R2: When MA_W < 32 and NIB_POS is 2..7, slave_addr[4*NIB_POS+3:4*NIB_POS] equals paddr[MA_W-1:MA_W-4].
- R3: With NIB_POS = 8, the master's top nibble does not appear in slave_addr. Every bit at or above MA_W-4 then comes from the upper-bit source.
- R4: With IND_SRC = 0, every slave_addr bit that is not taken from paddr is zero.
- R5: With IND_SRC = 1, every slave_addr bit that is not taken from paddr equals ext_upper at the same bit index.
- R6: With IND_SRC = 2..17, every slave_addr bit that is not taken from paddr equals the same bit of the internal register. The register occupies slot IND_SRC-2, where the slot number is paddr[MA_W-1:MA_W-4].
- R7: With DATA_W = 32, the whole register is at slot offset 0x0. The slot offset is paddr[MA_W-5:0].
- R8: With DATA_W = 16, offset 0x0 holds register bits [15:0] and offset 0x4 holds bits [31:16].
- R9: With DATA_W = 8, offsets 0x0, 0x4, 0x8 and 0xC hold register bits [7:0], [15:8], [23:16] and [31:24].
- R10: With MA_W = 32, slave_addr equals paddr whatever NIB_POS and IND_SRC are set to.
- R11: Reset clears the register to zero.
- R12: The register is written only when psel, penable and pwrite are all high and paddr hits the register slot. A setup phase alone, or an access to another slot, leaves it unchanged.
- R13: Register reads at any other offset in the slot return zero, and writes there are ignored. ind_ready is always 1 and ind_err is always 0.
- R14: ind_sel is high exactly when psel is high and paddr falls in the register slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Master select |
| penable | input | 1 | Master access phase |
| pwrite | input | 1 | Master write flag |
| paddr | input | 32 | Master address; bits above MA_W tied low |
| pwdata | input | 32 | Master write data; low DATA_W bits used |
| ext_upper | input | 32 | External upper-bit source (IND_SRC = 1) |
| slave_addr | output | 32 | Expanded address to all slaves |
| ind_sel | output | 1 | Access targets the register slot |
| ind_rdata | output | 32 | Register read data, zero-extended |
| ind_ready | output | 1 | Register slot ready (always 1) |
| ind_err | output | 1 | Register slot error (always 0) |

## Verification
The bench builds five instances side by side. Each covers a different configuration:

- A 12-bit master with the nibble at [31:28] and a byte-wide register in slot 5. This exercises the four-byte layout, writes at unused offsets, writes in the setup phase only, and writes to a foreign slot.
- A 16-bit master with the nibble at [23:20] and a 16-bit register in slot 0. This covers the two-half layout.
- A 20-bit master that drops the nibble and takes its upper bits from ext_upper.
- A 24-bit master with no indirect source, so the zero fill can be seen.
- A 32-bit master with a word register in slot 15. This shows that the address is copied unchanged and that the single-word register still works.

// File: rtl/aex_pkg.sv
package aex_pkg;
  // Upper-bit source selector values
  localparam int SRC_NONE = 0;
  localparam int SRC_EXT  = 1;

  function automatic bit src_is_reg(input int src);
    return src >= 2;
  endfunction

  function automatic int src_slot(input int src);
    return (src >= 2) ? src - 2 : 0;
  endfunction

  function automatic int lanes_of(input int dw);
    return 32 / dw;
  endfunction
endpackage

// File: rtl/aex_addr_mux.sv
module aex_addr_mux #(
  parameter int MA_W    = 12,
  parameter int NIB_POS = 7
) (
  input  logic [31:0] paddr,
  input  logic [31:0] upper_src,
  output logic [31:0] slave_addr
);
  localparam int LOWW = MA_W - 4;
  localparam int NLO  = 4 * NIB_POS;

  logic unused_mux;
  assign unused_mux = ^{paddr, upper_src};

  generate
    if (MA_W >= 32) begin : g_full
      assign slave_addr = paddr;
    end else begin : g_narrow
      for (genvar b = 0; b < 32; b++) begin : g_bit
        if (b < LOWW) begin : g_low
          assign slave_addr[b] = paddr[b];
        end else if (NIB_POS < 8 && b >= NLO && b < NLO + 4) begin : g_nib
          assign slave_addr[b] = paddr[LOWW + b - NLO];
        end else begin : g_up
          assign slave_addr[b] = upper_src[b];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/aex_ind_reg.sv
module aex_ind_reg #(
  parameter int MA_W   = 12,
  parameter int DATA_W = 8,
  parameter int SLOT   = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [31:0] paddr,
  input  logic [31:0] pwdata,
  output logic        sel,
  output logic [31:0] rdata,
  output logic [31:0] ind_q
);
  localparam int NREG = aex_pkg::lanes_of(DATA_W);
  localparam int OFFW = MA_W - 4;

  logic [OFFW-1:0] offset;
  logic [NREG-1:0] lane_hit;
  logic            wr_go;
  logic [31:0]     ind_d;

  logic unused_reg;
  assign unused_reg = ^{paddr, pwdata};

  assign offset = paddr[OFFW-1:0];
  assign sel    = psel && (paddr[MA_W-1:MA_W-4] == 4'(SLOT));
  assign wr_go  = sel && penable && pwrite;

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_lane
      assign lane_hit[i] = (offset == OFFW'(4 * i));
    end
  endgenerate

  always_comb begin
    ind_d = ind_q;
    for (int i = 0; i < NREG; i++) begin
      if (wr_go && lane_hit[i]) begin
        ind_d[i*DATA_W +: DATA_W] = pwdata[DATA_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ind_q <= '0;
    end else if (wr_go) begin
      ind_q <= ind_d;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (lane_hit[i]) begin
        rdata[DATA_W-1:0] = ind_q[i*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/apb_addr_expander.sv
module apb_addr_expander #(
  parameter int MA_W    = 12,
  parameter int NIB_POS = 7,
  parameter int IND_SRC = 7,
  parameter int DATA_W  = 8
) (
  input  logic        pclk,
  input  logic        presetn,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [31:0] paddr,
  input  logic [31:0] pwdata,
  input  logic [31:0] ext_upper,
  output logic [31:0] slave_addr,
  output logic        ind_sel,
  output logic [31:0] ind_rdata,
  output logic        ind_ready,
  output logic        ind_err
);
  logic [1:0]  rst_pipe_q;
  logic [1:0]  rst_pipe_d;
  logic        rst_sync;
  logic [31:0] upper_src;

  logic unused_top;
  assign unused_top = ^{ext_upper, pwdata, psel, penable, pwrite};

  // Reset release synchroniser
  assign rst_pipe_d = {rst_pipe_q[0], 1'b1};

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= rst_pipe_d;
    end
  end

  assign rst_sync = rst_pipe_q[1];

  generate
    if (aex_pkg::src_is_reg(IND_SRC)) begin : g_reg
      aex_ind_reg #(
        .MA_W  (MA_W),
        .DATA_W(DATA_W),
        .SLOT  (aex_pkg::src_slot(IND_SRC))
      ) u_ind_reg (
        .clk    (pclk),
        .rst_n  (rst_sync),
        .psel   (psel),
        .penable(penable),
        .pwrite (pwrite),
        .paddr  (paddr),
        .pwdata (pwdata),
        .sel    (ind_sel),
        .rdata  (ind_rdata),
        .ind_q  (upper_src)
      );
    end else begin : g_noreg
      assign ind_sel   = 1'b0;
      assign ind_rdata = '0;
      if (IND_SRC == aex_pkg::SRC_EXT) begin : g_ext
        assign upper_src = ext_upper;
      end else begin : g_zero
        assign upper_src = '0;
      end
    end
  endgenerate

  assign ind_ready = 1'b1;
  assign ind_err   = 1'b0;

  aex_addr_mux #(
    .MA_W   (MA_W),
    .NIB_POS(NIB_POS)
  ) u_addr_mux (
    .paddr     (paddr),
    .upper_src (upper_src),
    .slave_addr(slave_addr)
  );
endmodule

// File: rtl/aex_checker.sv
module aex_checker #(
  parameter int MA_W    = 12,
  parameter int NIB_POS = 7,
  parameter int IND_SRC = 7,
  parameter int DATA_W  = 8
) (
  input logic        pclk,
  input logic        presetn,
  input logic        rst_sync,
  input logic        psel,
  input logic        penable,
  input logic        pwrite,
  input logic [31:0] paddr,
  input logic [31:0] pwdata,
  input logic [31:0] upper_src,
  input logic [31:0] slave_addr,
  input logic        ind_sel,
  input logic [31:0] ind_rdata
);
  localparam int OFFW = MA_W - 4;
  localparam int NREG = 32 / DATA_W;

  logic [OFFW-1:0] off;
  logic            off_ok;
  assign off    = paddr[OFFW-1:0];
  assign off_ok = (off[1:0] == 2'b00) && ((off >> 2) < OFFW'(NREG));

  generate
    if (IND_SRC >= 2) begin : g_reg_chk
      AST_HOLD_NO_WRITE: assert property (@(posedge pclk) disable iff (!presetn)
        !(ind_sel && penable && pwrite) |=> $stable(upper_src)); // R12
      AST_RESET_CLEAR: assert property (@(posedge pclk) disable iff (!presetn)
        !rst_sync |-> upper_src == 32'd0); // R11
      AST_BAD_OFFSET_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
        (ind_sel && !off_ok) |-> ind_rdata == 32'd0); // R13
      AST_LANE0_WRITE: assert property (@(posedge pclk) disable iff (!presetn)
        (rst_sync && ind_sel && penable && pwrite && off == '0)
        |=> upper_src[DATA_W-1:0] == $past(pwdata[DATA_W-1:0])); // R7
    end
    if (MA_W >= 32) begin : g_full_chk
      AST_MIRROR: assert property (@(posedge pclk) disable iff (!presetn)
        slave_addr == paddr); // R10
    end else if (NIB_POS < 8) begin : g_nib_chk
      AST_NIBBLE_PLACE: assert property (@(posedge pclk) disable iff (!presetn)
        slave_addr[4*NIB_POS +: 4] == paddr[MA_W-4 +: 4]); // R2
    end
  endgenerate
endmodule

bind apb_addr_expander aex_checker #(
  .MA_W   (MA_W),
  .NIB_POS(NIB_POS),
  .IND_SRC(IND_SRC),
  .DATA_W (DATA_W)
) u_aex_chk (
  .pclk      (pclk),
  .presetn   (presetn),
  .rst_sync  (rst_sync),
  .psel      (psel),
  .penable   (penable),
  .pwrite    (pwrite),
  .paddr     (paddr),
  .pwdata    (pwdata),
  .upper_src (upper_src),
  .slave_addr(slave_addr),
  .ind_sel   (ind_sel),
  .ind_rdata (ind_rdata)
);

// File: tb/test_apb_addr_expander.sv
module test_apb_addr_expander;
  logic        clk = 1'b0;
  logic        presetn = 1'b0;
  logic [4:0]  psel = '0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [31:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] ext_upper = '0;

  logic [31:0] sa [5];
  logic [31:0] rd [5];
  logic        sel [5];
  logic        rdy [5];
  logic        err [5];

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  // A: 12-bit master, nibble at [31:28], byte register in slot 5
  apb_addr_expander #(.MA_W(12), .NIB_POS(7), .IND_SRC(7), .DATA_W(8)) i_apb_addr_expander (
    .pclk(clk), .presetn(presetn), .psel(psel[0]), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .ext_upper(ext_upper), .slave_addr(sa[0]),
    .ind_sel(sel[0]), .ind_rdata(rd[0]), .ind_ready(rdy[0]), .ind_err(err[0]));
  // B: 16-bit master, nibble at [23:20], half-word register in slot 0
  apb_addr_expander #(.MA_W(16), .NIB_POS(5), .IND_SRC(2), .DATA_W(16)) i_apb_addr_expander_b (
    .pclk(clk), .presetn(presetn), .psel(psel[1]), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .ext_upper(ext_upper), .slave_addr(sa[1]),
    .ind_sel(sel[1]), .ind_rdata(rd[1]), .ind_ready(rdy[1]), .ind_err(err[1]));
  // C: 20-bit master, nibble dropped, external upper bits
  apb_addr_expander #(.MA_W(20), .NIB_POS(8), .IND_SRC(1), .DATA_W(32)) i_apb_addr_expander_c (
    .pclk(clk), .presetn(presetn), .psel(psel[2]), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .ext_upper(ext_upper), .slave_addr(sa[2]),
    .ind_sel(sel[2]), .ind_rdata(rd[2]), .ind_ready(rdy[2]), .ind_err(err[2]));
  // D: 24-bit master, nibble at [27:24], no indirect source
  apb_addr_expander #(.MA_W(24), .NIB_POS(6), .IND_SRC(0), .DATA_W(32)) i_apb_addr_expander_d (
    .pclk(clk), .presetn(presetn), .psel(psel[3]), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .ext_upper(ext_upper), .slave_addr(sa[3]),
    .ind_sel(sel[3]), .ind_rdata(rd[3]), .ind_ready(rdy[3]), .ind_err(err[3]));
  // E: 32-bit master, word register in slot 15
  apb_addr_expander #(.MA_W(32), .NIB_POS(7), .IND_SRC(17), .DATA_W(32)) i_apb_addr_expander_e (
    .pclk(clk), .presetn(presetn), .psel(psel[4]), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .ext_upper(ext_upper), .slave_addr(sa[4]),
    .ind_sel(sel[4]), .ind_rdata(rd[4]), .ind_ready(rdy[4]), .ind_err(err[4]));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic apb_wr(input int k, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    psel[k] = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = '0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input int k, input logic [31:0] a, output logic [31:0] d,
                        output logic s, output logic r, output logic e);
    @(negedge clk);
    psel[k] = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #2;
    d = rd[k]; s = sel[k]; r = rdy[k]; e = err[k];
    @(negedge clk);
    psel = '0; penable = 1'b0;
  endtask

  task automatic set_addr(input logic [31:0] a);
    @(negedge clk);
    paddr = a;
    #2;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic s, r, e;
    set_addr(32'h0000_0A5C);
    chk("R11 cleared register in A slave_addr", sa[0], 32'hA000_005C);
    apb_rd(0, 32'h500, d, s, r, e);
    chk("R11 cleared register read", d, 32'h0);
  endtask

  task automatic t_a_bytes();
    logic [31:0] d; logic s, r, e;
    apb_wr(0, 32'h500, 32'h11);
    apb_wr(0, 32'h504, 32'h22);
    apb_wr(0, 32'h508, 32'h33);
    apb_wr(0, 32'h50C, 32'h44);
    set_addr(32'h0000_0A5C);
    chk("R1 R2 R6 R9 byte layout in slave_addr", sa[0], 32'hA433_225C);
    apb_rd(0, 32'h504, d, s, r, e);
    chk("R9 byte at offset 0x4", d, 32'h22);
    chk("R14 slot hit sel", {31'b0, s}, 32'h1);
    chk("R13 ready high", {31'b0, r}, 32'h1);
    chk("R13 error low", {31'b0, e}, 32'h0);
  endtask

  task automatic t_a_ignore();
    logic [31:0] d; logic s, r, e;
    apb_rd(0, 32'h510, d, s, r, e);
    chk("R13 unused offset reads zero", d, 32'h0);
    apb_wr(0, 32'h510, 32'hFF);
    apb_wr(0, 32'h502, 32'hEE);
    apb_wr(0, 32'h600, 32'hDD);
    // setup phase only: no access phase follows
    @(negedge clk);
    psel[0] = 1'b1; pwrite = 1'b1; paddr = 32'h500; pwdata = 32'h99; penable = 1'b0;
    @(negedge clk);
    psel = '0; pwrite = 1'b0;
    set_addr(32'h0000_0A5C);
    chk("R12 R13 register unchanged by ignored writes", sa[0], 32'hA433_225C);
    apb_rd(0, 32'h500, d, s, r, e);
    chk("R12 byte 0 unchanged", d, 32'h11);
    apb_rd(0, 32'h600, d, s, r, e);
    chk("R14 foreign slot no sel", {31'b0, s}, 32'h0);
  endtask

  task automatic t_b_halves();
    logic [31:0] d; logic s, r, e;
    apb_wr(1, 32'h0000, 32'hBEEF);
    apb_wr(1, 32'h0004, 32'hDEAD);
    set_addr(32'h0000_3123);
    chk("R2 R6 R8 half layout in slave_addr", sa[1], 32'hDE3D_B123);
    apb_rd(1, 32'h0004, d, s, r, e);
    chk("R8 upper half at offset 0x4", d, 32'hDEAD);
    apb_rd(1, 32'h0008, d, s, r, e);
    chk("R13 offset 0x8 reads zero at 16-bit width", d, 32'h0);
  endtask

  task automatic t_c_ext();
    @(negedge clk);
    ext_upper = 32'h89AB_CDEF;
    set_addr(32'h0007_1234);
    chk("R3 R5 nibble dropped, external upper bits", sa[2], 32'h89AB_1234);
  endtask

  task automatic t_d_zero();
    @(negedge clk);
    ext_upper = 32'hFFFF_FFFF;
    set_addr(32'h00C5_6789);
    chk("R4 zero fill", sa[3], 32'h0C05_6789);
  endtask

  task automatic t_e_full();
    logic [31:0] d; logic s, r, e;
    apb_wr(4, 32'hF000_0000, 32'h1234_5678);
    apb_rd(4, 32'hF000_0000, d, s, r, e);
    chk("R7 word register", d, 32'h1234_5678);
    apb_rd(4, 32'hF000_0004, d, s, r, e);
    chk("R13 offset 0x4 reads zero at 32-bit width", d, 32'h0);
    set_addr(32'h9ABC_DEF0);
    chk("R10 full-width mirror", sa[4], 32'h9ABC_DEF0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    presetn = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_a_bytes();
    t_a_ignore();
    t_b_halves();
    t_c_ext();
    t_d_zero();
    t_e_full();
    repeat (2) @(negedge clk);
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end
endmodule